// File: doc/BRIEF.md
# DMA Interrupt Coalescing and Status Controller

This block keeps the control word, the status word and the two descriptor pointer registers of a copy engine, and drives a single level-sensitive interrupt line. Completion pulses from the engine are not reported one at a time. Instead, they are batched. A completion interrupt fires only once a programmable number of completions has arrived. A delay timer, which advances on a prescaled tick, raises a separate interrupt when no further completion restarts it before it runs out. Error events from the engine are latched as sticky flags, and each one also raises an error interrupt.

Software programs the block through a single-cycle write port and reads it through a combinational read port, both selected by a 2-bit register index: 0 is control, 1 is status, 2 is the current pointer and 3 is the tail pointer. The status word shows the live batch counter and the live timer count, so software can see how far a batch has progressed. The mode bits of the control word are also brought out to the data mover as separate outputs.

Top module: `irq_coalesce_ctrl`

## Requirements
- R1: After reset:
  - control reads 0x00010002;
  - status reads 0x0001000A while `busy` is low;
  - both pointers read 0;
  - `irq` is low.
- R2: A control write without bit 2 stores the data ANDed with 0xFFFF707C, with bit 1 forced to 1. The outputs `sg_mode`, `keyhole_rd`, `keyhole_wr` and `cyclic_en` follow control bits 3, 4, 5 and 6.
- R3: Control bits 23:16 hold the batch threshold.
  - A write of 0 to this field keeps the previous threshold.
  - Every control write without bit 2 reloads the batch counter with the threshold that results.
  - Such a write in the same cycle as a completion takes precedence, and that completion is not counted.
- R4: Each completion pulse decrements the batch counter. A completion that finds the counter at 1 sets status bit 12 and reloads the counter from the threshold.
- R5: Control bits 31:24 hold the delay value.
  - A completion with a nonzero delay value loads the timer with that value and starts it. A zero delay value leaves the timer untouched.
  - Each `tick` decrements the running timer.
  - When the timer reaches 0, it stops, sets status bit 13 and reloads the batch counter.
- R6: A `tick` in the same cycle as a completion is ignored. `run_end` stops the timer and freezes its count, even when a completion arrives in the same cycle.
- R7: The status read layout is as follows:
  - bit 1 is the inverse of `busy`;
  - bit 3 is 1;
  - bits 23:16 are the live counter;
  - bits 31:24 are the live timer;
  - `err_evt[2:0]` map to bits 4..6 and `err_evt[5:3]` map to bits 8..10;
  - all other bits read 0.
- R8: Status bits 12, 13 and 14 are write-1-to-clear, and a status write leaves every other status bit unchanged. A set in the same cycle as a clear wins.
- R9: Any asserted `err_evt` bit sets its own status bit and status bit 14. The error flag bits stay set until a soft reset.
- R10: `irq` is high exactly when some status bit among 12..14 is set and the control bit in the same position is also set.
- R11: A control write with bit 2 set does the following:
  - returns control, status, the counter and the timer to their R1 values;
  - drops `irq`;
  - ignores every other bit of that write.
- R12: The pointer registers:
  - accept writes only while control bit 3 is set, and store the data with bits 5:0 cleared;
  - are both cleared, together with status bit 13, by a control write that has bit 3 clear and bit 2 clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_sel | input | 2 | Write register index (0 control, 1 status, 2 current pointer, 3 tail pointer) |
| wr_data | input | 32 | Write data |
| rd_sel | input | 2 | Read register index, same encoding as `wr_sel` |
| rd_data | output | 32 | Combinational read data for `rd_sel` |
| cmpl_pulse | input | 1 | One-cycle pulse per completed transfer |
| err_evt | input | 6 | Error event pulses, one bit per error kind |
| run_end | input | 1 | End of a descriptor run; stops the delay timer |
| busy | input | 1 | Engine busy level |
| tick | input | 1 | Prescaled timer tick |
| irq | output | 1 | Level interrupt |
| sg_mode | output | 1 | Descriptor-chain mode bit |
| keyhole_rd | output | 1 | Fixed-address read mode bit |
| keyhole_wr | output | 1 | Fixed-address write mode bit |
| cyclic_en | output | 1 | Cyclic descriptor ring mode bit |

## Verification
Directed sequences cover three timing patterns:
- completions alone, which show that a batch fires on the threshold count and not one pulse early;
- completions followed by ticks, which show that a timeout is counted from the last completion;
- completions coinciding with ticks, `run_end`, status clears and control writes, which resolve each same-cycle priority.

A long random phase then mixes all inputs with small thresholds and delay values, so batches, timeouts, soft resets and mode changes interleave in orders the directed cases do not reach. After every cycle, all four readable registers, the interrupt and the mode outputs are compared against a behavioural model.

// File: rtl/icc_pkg.sv
// Package: field positions, reset values and register indices shared by
// the coalescing controller. Assumes a 32-bit register data path.
package icc_pkg;
    localparam int DW        = 32;
    localparam int CNT_W     = 8;    // batch counter and threshold width
    localparam int TMR_W     = 8;    // delay timer width
    localparam int ERR_N     = 6;    // number of error event kinds
    localparam int PTR_ALIGN = 6;    // pointer alignment in bits

    localparam int THR_LSB   = 16;   // control and status counter field
    localparam int DLY_LSB   = 24;   // control delay / status timer field
    localparam int TAIL_BIT  = 1;
    localparam int RST_BIT   = 2;
    localparam int SG_BIT    = 3;
    localparam int IDLE_BIT  = 1;
    localparam int SGI_BIT   = 3;
    localparam int IOC_BIT   = 12;
    localparam int DLYI_BIT  = 13;
    localparam int ERRI_BIT  = 14;

    localparam logic [DW-1:0] CTRL_WMASK = 32'hFFFF_707C;
    localparam logic [DW-1:0] CTRL_RST   = 32'h0001_0002;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_STAT = 2'd1,
        SEL_CUR  = 2'd2,
        SEL_TAIL = 2'd3
    } reg_sel_e;

    // Status bit position of error event kind i (bits 4..6, then 8..10).
    function automatic int err_pos(int i);
        return (i < 3) ? 4 + i : 5 + i;
    endfunction
endpackage

// File: rtl/icc_cfg_regs.sv
// Control word and descriptor pointers. Decodes soft reset and threshold
// merging for a control write. Assumes at most one register write per cycle.
module icc_cfg_regs
    import icc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_wr,
    input  logic             cur_wr,
    input  logic             tail_wr,
    input  logic [DW-1:0]    wr_data,
    output logic [DW-1:0]    ctrl_q,
    output logic [DW-1:0]    cur_q,
    output logic [DW-1:0]    tail_q,
    output logic             soft_rst,
    output logic             cfg_load,
    output logic             sg_off_wr,
    output logic [CNT_W-1:0] new_thr
);
    localparam logic [DW-1:0] PTR_MASK = {{(DW-PTR_ALIGN){1'b1}}, {PTR_ALIGN{1'b0}}};

    logic [DW-1:0] merged;

    // Decode the effect of a control write and build the value to store.
    always_comb begin
        soft_rst  = ctrl_wr & wr_data[RST_BIT];
        cfg_load  = ctrl_wr & ~wr_data[RST_BIT];
        sg_off_wr = cfg_load & ~wr_data[SG_BIT];
        new_thr   = (wr_data[THR_LSB +: CNT_W] == '0) ? ctrl_q[THR_LSB +: CNT_W]
                                                      : wr_data[THR_LSB +: CNT_W];
        merged    = (wr_data & CTRL_WMASK) | (DW'(1) << TAIL_BIT);
        merged[THR_LSB +: CNT_W] = new_thr;
    end

    // Control register: reset value on reset or soft reset, else merged write.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) ctrl_q <= CTRL_RST;
        else if (cfg_load)      ctrl_q <= merged;
    end

    // Pointers: cleared when descriptor mode is written off, written only in it.
    always_ff @(posedge clk) begin
        if (!rst_n || sg_off_wr) begin
            cur_q  <= '0;
            tail_q <= '0;
        end else begin
            if (cur_wr && ctrl_q[SG_BIT])  cur_q  <= wr_data & PTR_MASK;
            if (tail_wr && ctrl_q[SG_BIT]) tail_q <= wr_data & PTR_MASK;
        end
    end

    assert_thr_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_load && wr_data[THR_LSB +: CNT_W] != '0)
        |=> ctrl_q[THR_LSB +: CNT_W] == $past(wr_data[THR_LSB +: CNT_W]));

    assert_ptr_align_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_wr && ctrl_q[SG_BIT] && !sg_off_wr) |=> cur_q[PTR_ALIGN-1:0] == '0
        && cur_q[DW-1:PTR_ALIGN] == $past(wr_data[DW-1:PTR_ALIGN]));
endmodule

// File: rtl/icc_coalesce.sv
// Batch counter and delay timer. Produces one-cycle set requests for the
// completion and timeout interrupt flags. Assumes tick is a one-cycle pulse.
module icc_coalesce
    import icc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             cfg_load,
    input  logic [CNT_W-1:0] new_thr,
    input  logic [CNT_W-1:0] thr_q,
    input  logic [TMR_W-1:0] delay_val,
    input  logic             cmpl,
    input  logic             tick,
    input  logic             run_end,
    output logic [CNT_W-1:0] cnt_q,
    output logic [TMR_W-1:0] tmr_q,
    output logic             ioc_set,
    output logic             dly_set
);
    logic tmr_run;
    logic restart;
    logic tmr_step;

    // Event qualification for counter and timer.
    always_comb begin
        restart  = cmpl && (delay_val != '0) && !run_end;
        tmr_step = tmr_run && tick && !cmpl && !run_end;
        dly_set  = !soft_rst && tmr_step && (tmr_q == TMR_W'(1));
        ioc_set  = !soft_rst && !cfg_load && cmpl && (cnt_q == CNT_W'(1));
    end

    // Delay timer: restart on completion, count ticks, freeze on run end.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            tmr_q   <= '0;
            tmr_run <= 1'b0;
        end else if (run_end) begin
            tmr_run <= 1'b0;
        end else if (restart) begin
            tmr_q   <= delay_val;
            tmr_run <= 1'b1;
        end else if (tmr_step) begin
            tmr_q <= tmr_q - TMR_W'(1);
            if (tmr_q == TMR_W'(1)) tmr_run <= 1'b0;
        end
    end

    // Batch counter: reload on config, count completions, reload on batch or timeout.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst)  cnt_q <= CNT_W'(1);
        else if (cfg_load)       cnt_q <= new_thr;
        else if (cmpl)           cnt_q <= (cnt_q == CNT_W'(1)) ? thr_q : cnt_q - CNT_W'(1);
        else if (dly_set)        cnt_q <= thr_q;
    end

    assert_cnt_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q != '0);

    assert_tmr_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (run_end && !soft_rst) |=> tmr_q == $past(tmr_q));
endmodule

// File: rtl/icc_status_flags.sv
// Sticky interrupt and error flags with write-1-to-clear on the interrupt
// bits. A set request in the same cycle as a clear wins.
module icc_status_flags
    import icc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             stat_wr,
    input  logic [2:0]       w1c,       // data bits 14..12 of a status write
    input  logic             sg_off_wr,
    input  logic             ioc_set,
    input  logic             dly_set,
    input  logic [ERR_N-1:0] err_evt,
    output logic             ioc_q,
    output logic             dly_q,
    output logic             err_q,
    output logic [ERR_N-1:0] ef_q
);
    // Interrupt flags: clear by write-1 (or mode-off for timeout), set wins.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            ioc_q <= 1'b0;
            dly_q <= 1'b0;
            err_q <= 1'b0;
        end else begin
            ioc_q <= (ioc_q & ~(stat_wr & w1c[0])) | ioc_set;
            dly_q <= (dly_q & ~(stat_wr & w1c[1]) & ~sg_off_wr) | dly_set;
            err_q <= (err_q & ~(stat_wr & w1c[2])) | (|err_evt);
        end
    end

    // One sticky flag per error kind, cleared only by reset.
    for (genvar i = 0; i < ERR_N; i++) begin : g_err
        always_ff @(posedge clk) begin
            if (!rst_n || soft_rst) ef_q[i] <= 1'b0;
            else if (err_evt[i])    ef_q[i] <= 1'b1;
        end
    end

    assert_ioc_w1c_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && w1c[0] && !ioc_set) |=> !ioc_q);

    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((|err_evt) && !soft_rst) |=> err_q);
endmodule

// File: rtl/irq_coalesce_ctrl.sv
// Top: register decode, status assembly, read mux and interrupt output of the
// coalescing controller. Assumes a single-cycle write port and a read port
// without side effects.
module irq_coalesce_ctrl
    import icc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [DW-1:0]    wr_data,
    input  logic [1:0]       rd_sel,
    output logic [DW-1:0]    rd_data,
    input  logic             cmpl_pulse,
    input  logic [ERR_N-1:0] err_evt,
    input  logic             run_end,
    input  logic             busy,
    input  logic             tick,
    output logic             irq,
    output logic             sg_mode,
    output logic             keyhole_rd,
    output logic             keyhole_wr,
    output logic             cyclic_en
);
    logic             ctrl_wr, stat_wr, cur_wr, tail_wr;
    logic [DW-1:0]    ctrl_q, cur_q, tail_q, stat_word;
    logic             soft_rst, cfg_load, sg_off_wr;
    logic [CNT_W-1:0] new_thr, cnt_q;
    logic [TMR_W-1:0] tmr_q;
    logic             ioc_set, dly_set, ioc_q, dly_q, err_q;
    logic [ERR_N-1:0] ef_q;

    // Write decode by register index.
    always_comb begin
        ctrl_wr = wr_en && (wr_sel == SEL_CTRL);
        stat_wr = wr_en && (wr_sel == SEL_STAT);
        cur_wr  = wr_en && (wr_sel == SEL_CUR);
        tail_wr = wr_en && (wr_sel == SEL_TAIL);
    end

    icc_cfg_regs u_cfg (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .cur_wr(cur_wr),
        .tail_wr(tail_wr), .wr_data(wr_data), .ctrl_q(ctrl_q), .cur_q(cur_q),
        .tail_q(tail_q), .soft_rst(soft_rst), .cfg_load(cfg_load),
        .sg_off_wr(sg_off_wr), .new_thr(new_thr)
    );

    icc_coalesce u_coal (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .cfg_load(cfg_load),
        .new_thr(new_thr), .thr_q(ctrl_q[THR_LSB +: CNT_W]),
        .delay_val(ctrl_q[DLY_LSB +: TMR_W]), .cmpl(cmpl_pulse), .tick(tick),
        .run_end(run_end), .cnt_q(cnt_q), .tmr_q(tmr_q), .ioc_set(ioc_set),
        .dly_set(dly_set)
    );

    icc_status_flags u_flags (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .stat_wr(stat_wr),
        .w1c(wr_data[ERRI_BIT:IOC_BIT]), .sg_off_wr(sg_off_wr),
        .ioc_set(ioc_set), .dly_set(dly_set), .err_evt(err_evt),
        .ioc_q(ioc_q), .dly_q(dly_q), .err_q(err_q), .ef_q(ef_q)
    );

    // Assemble the status word from live counter, timer and flags.
    always_comb begin
        stat_word = '0;
        stat_word[IDLE_BIT] = ~busy;
        stat_word[SGI_BIT]  = 1'b1;
        for (int i = 0; i < ERR_N; i++) stat_word[err_pos(i)] = ef_q[i];
        stat_word[IOC_BIT]  = ioc_q;
        stat_word[DLYI_BIT] = dly_q;
        stat_word[ERRI_BIT] = err_q;
        stat_word[THR_LSB +: CNT_W] = cnt_q;
        stat_word[DLY_LSB +: TMR_W] = tmr_q;
    end

    // Read mux.
    always_comb begin
        case (rd_sel)
            SEL_CTRL: rd_data = ctrl_q;
            SEL_STAT: rd_data = stat_word;
            SEL_CUR:  rd_data = cur_q;
            default:  rd_data = tail_q;
        endcase
    end

    // Interrupt line and mode outputs.
    always_comb begin
        irq        = |({err_q, dly_q, ioc_q} & ctrl_q[ERRI_BIT:IOC_BIT]);
        sg_mode    = ctrl_q[SG_BIT];
        keyhole_rd = ctrl_q[4];
        keyhole_wr = ctrl_q[5];
        cyclic_en  = ctrl_q[6];
    end

    assert_softrst_irq_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_CTRL && wr_data[RST_BIT]) |=> !irq);
endmodule

// File: tb/irq_coalesce_ctrl_test.sv
module irq_coalesce_ctrl_test;
    import icc_pkg::*;

    logic        clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n, wr_en, cmpl_pulse, run_end, busy, tick;
    logic [1:0]  wr_sel, rd_sel;
    logic [31:0] wr_data, rd_data;
    logic [5:0]  err_evt;
    logic        irq, sg_mode, keyhole_rd, keyhole_wr, cyclic_en;

    irq_coalesce_ctrl uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
        .cmpl_pulse(cmpl_pulse), .err_evt(err_evt), .run_end(run_end),
        .busy(busy), .tick(tick), .irq(irq), .sg_mode(sg_mode),
        .keyhole_rd(keyhole_rd), .keyhole_wr(keyhole_wr), .cyclic_en(cyclic_en)
    );

    int checks = 0;
    int failures = 0;

    // Behavioural model state.
    logic [31:0] m_ctrl, m_cur, m_tail;
    logic [7:0]  m_cnt, m_tmr;
    logic        m_run, m_ioc, m_dly, m_err;
    logic [5:0]  m_ef;

    task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, got, exp);
        end
    endtask

    function automatic logic [31:0] m_status();
        return {m_tmr, m_cnt, 1'b0, m_err, m_dly, m_ioc, 1'b0, m_ef[5:3],
                1'b0, m_ef[2:0], 1'b1, 1'b0, ~busy, 1'b0};
    endfunction

    function automatic logic [31:0] m_read(int s);
        case (s)
            0: return m_ctrl;
            1: return m_status();
            2: return m_cur;
            default: return m_tail;
        endcase
    endfunction

    task automatic m_reset_core();
        m_ctrl = 32'h0001_0002; m_cnt = 8'd1; m_tmr = 8'd0; m_run = 1'b0;
        m_ioc = 1'b0; m_dly = 1'b0; m_err = 1'b0; m_ef = '0;
    endtask

    // Model of one clock edge from the requirements.
    task automatic m_update();
        logic ctrl_w, stat_w, fire, ioc_s;
        logic [7:0] thr_old, nthr;
        logic [31:0] d;
        d = wr_data;
        ctrl_w = wr_en && wr_sel == 2'd0;
        stat_w = wr_en && wr_sel == 2'd1;
        if (ctrl_w && d[2]) begin
            m_reset_core();
            return;
        end
        thr_old = m_ctrl[23:16];
        fire = 1'b0; ioc_s = 1'b0;
        if (run_end) m_run = 1'b0;
        else if (cmpl_pulse && m_ctrl[31:24] != 0) begin
            m_tmr = m_ctrl[31:24]; m_run = 1'b1;
        end else if (m_run && tick && !cmpl_pulse) begin
            if (m_tmr == 8'd1) begin m_tmr = 0; m_run = 0; fire = 1; end
            else m_tmr = m_tmr - 1;
        end
        nthr = (d[23:16] == 0) ? thr_old : d[23:16];
        if (ctrl_w) m_cnt = nthr;
        else if (cmpl_pulse) begin
            if (m_cnt == 8'd1) begin m_cnt = thr_old; ioc_s = 1; end
            else m_cnt = m_cnt - 1;
        end else if (fire) m_cnt = thr_old;
        m_ioc = (m_ioc & ~(stat_w & d[12])) | ioc_s;
        m_dly = (m_dly & ~(stat_w & d[13]) & ~(ctrl_w & ~d[3])) | fire;
        m_err = (m_err & ~(stat_w & d[14])) | (|err_evt);
        m_ef  = m_ef | err_evt;
        if (wr_en && wr_sel == 2'd2 && m_ctrl[3]) m_cur  = d & 32'hFFFF_FFC0;
        if (wr_en && wr_sel == 2'd3 && m_ctrl[3]) m_tail = d & 32'hFFFF_FFC0;
        if (ctrl_w) begin
            m_ctrl = (d & 32'hFFFF_707C) | 32'h2;
            m_ctrl[23:16] = nthr;
            if (!d[3]) begin m_cur = 0; m_tail = 0; end
        end
    endtask

    task automatic idle_inputs();
        wr_en = 0; wr_sel = 0; wr_data = 0; cmpl_pulse = 0;
        err_evt = 0; run_end = 0; tick = 0;
    endtask

    task automatic step();
        @(posedge clk);
        m_update();
        #2;
        idle_inputs();
    endtask

    task automatic compare_all(string req);
        for (int s = 0; s < 4; s++) begin
            rd_sel = 2'(s);
            #1;
            chk(req, $sformatf("reg%0d", s), rd_data, m_read(s));
        end
        chk(req, "irq", {31'd0, irq},
            {31'd0, |({m_err, m_dly, m_ioc} & m_ctrl[14:12])});
        chk(req, "mode", {28'd0, cyclic_en, keyhole_wr, keyhole_rd, sg_mode},
            {28'd0, m_ctrl[6:3]});
    endtask

    task automatic wr(logic [1:0] s, logic [31:0] d);
        wr_en = 1; wr_sel = s; wr_data = d;
        step();
    endtask

    task automatic done();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #2_000_000;
        checks++; failures++;
        $display("FAIL watchdog expired");
        done();
    end

    initial begin
        void'($urandom(32'd20240517));
        rst_n = 0; busy = 0; rd_sel = 0;
        idle_inputs();
        m_reset_core(); m_cur = 0; m_tail = 0;
        repeat (3) @(posedge clk);
        #2 rst_n = 1;
        #1;
        // R1 reset state
        compare_all("R1");
        rd_sel = 0; #1 chk("R1", "ctrl literal", rd_data, 32'h0001_0002);
        rd_sel = 1; #1 chk("R1", "status literal", rd_data, 32'h0001_000A);

        // R2 write mask and forced tail bit
        wr(0, 32'hFFFF_FFFB);
        rd_sel = 0; #1 chk("R2", "masked ctrl", rd_data, 32'hFFFF_707A);
        compare_all("R2");

        // R3 zero threshold keeps previous; R12 mode off clears pointers
        wr(0, 32'h0000_0000);
        rd_sel = 0; #1 chk("R3", "threshold kept", rd_data, 32'h00FF_0002);
        compare_all("R3");

        // R4 / R10 batch of three completions
        wr(0, 32'h0003_1008);
        cmpl_pulse = 1; step();
        cmpl_pulse = 1; step();
        rd_sel = 1; #1 chk("R4", "counter after two", {24'd0, rd_data[23:16]}, 32'd1);
        chk("R10", "no irq before batch", {31'd0, irq}, 32'd0);
        cmpl_pulse = 1; step();
        rd_sel = 1; #1 chk("R4", "ioc set and reload", rd_data & 32'h00FF_1000, 32'h0003_1000);
        chk("R10", "irq after batch", {31'd0, irq}, 32'd1);
        compare_all("R4");

        // R8 write-1-to-clear
        wr(1, 32'h0000_1000);
        chk("R8", "irq cleared", {31'd0, irq}, 32'd0);
        compare_all("R8");

        // R5 delay timeout
        wr(0, 32'h0302_2008);
        cmpl_pulse = 1; step();
        rd_sel = 1; #1 chk("R5", "timer loaded", {24'd0, rd_data[31:24]}, 32'd3);
        tick = 1; step();
        tick = 1; step();
        compare_all("R5");
        tick = 1; step();
        rd_sel = 1; #1 chk("R5", "timeout flags", rd_data & 32'hFFFF_2000, 32'h0002_2000);
        chk("R5", "irq on timeout", {31'd0, irq}, 32'd1);
        compare_all("R5");

        // R6 tick coinciding with completion, then run end freezes timer
        cmpl_pulse = 1; step();
        cmpl_pulse = 1; tick = 1; step();
        rd_sel = 1; #1 chk("R6", "tick ignored", {24'd0, rd_data[31:24]}, 32'd3);
        tick = 1; step();
        run_end = 1; cmpl_pulse = 1; step();
        tick = 1; step();
        rd_sel = 1; #1 chk("R6", "frozen timer", {24'd0, rd_data[31:24]}, 32'd2);
        compare_all("R6");

        // R12 pointer writes
        wr(2, 32'h1234_5677);
        rd_sel = 2; #1 chk("R12", "aligned pointer", rd_data, 32'h1234_5640);
        wr(0, 32'h0002_0000);
        wr(3, 32'hFFFF_FFFF);
        rd_sel = 3; #1 chk("R12", "tail ignored", rd_data, 32'h0);
        compare_all("R12");

        // R9 error events and R7 idle bit
        err_evt = 6'b100001; step();
        rd_sel = 1; #1 chk("R9", "error bits", rd_data & 32'h0000_4770, 32'h0000_4410);
        wr(0, 32'h0000_4000);
        chk("R9", "error irq", {31'd0, irq}, 32'd1);
        wr(1, 32'hFFFF_FFFF);
        compare_all("R9");
        busy = 1;
        rd_sel = 1; #1 chk("R7", "idle low when busy", {31'd0, rd_data[1]}, 32'd0);
        compare_all("R7");
        busy = 0;

        // R8 set wins over a same-cycle clear
        wr(0, 32'h0001_1008);
        cmpl_pulse = 1; wr(1, 32'h0000_1000);
        rd_sel = 1; #1 chk("R8", "set wins", {31'd0, rd_data[12]}, 32'd1);

        // R11 soft reset
        err_evt = 6'b000010; step();
        wr(0, 32'hFFFF_FFFF);
        rd_sel = 0; #1 chk("R11", "ctrl reset", rd_data, 32'h0001_0002);
        rd_sel = 1; #1 chk("R11", "status reset", rd_data, 32'h0001_000A);
        chk("R11", "irq low", {31'd0, irq}, 32'd0);
        compare_all("R11");

        // Random mix against the model (R3, R4, R5, R6, R8, R10)
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] d;
            cmpl_pulse = ($urandom % 4) == 0;
            tick       = ($urandom % 3) == 0;
            run_end    = ($urandom % 30) == 0;
            err_evt    = (($urandom % 60) == 0) ? 6'($urandom) : 6'd0;
            busy       = $urandom % 2;
            if (($urandom % 20) == 0) begin
                d = $urandom;
                wr_sel = 2'($urandom);
                if (wr_sel == 0) begin
                    d[31:24] = 8'($urandom % 5);
                    d[23:16] = 8'($urandom % 4);
                    d[2] = ($urandom % 40) == 0;
                end
                wr_en = 1; wr_data = d;
            end
            step();
            compare_all("RND_R4_R5");
        end
        done();
    end
endmodule